// File: doc/BRIEF.md
# Command-Unlocked Dual-Plane Write Protector

This block sits between a decoded processor bus and an 8K byte-alterable array held as two 4K planes, and decides which writes reach the array. It watches bus writes for unlock command sequences at fixed in-plane offsets. After the plain unlock it accepts one byte or page write while global protection is on. The longer sequences load an eight-bit block-lock mask or one of two map bytes, and one of them turns global protection off. Accepted bytes are gathered into a 32-byte page buffer. Each byte must follow the previous one within a load window. When the window lapses, a timed programming cycle starts on the target plane.

While that cycle runs, reads of the busy plane return a status byte whose bit 6 flips on each read. The other plane reads normally. A one-cycle end-of-write pulse marks completion. Both timers are parameters counted in system clocks, and the array is a plain behavioural register array.

Top module: `wg_write_guard`

## Requirements
- R1: After reset, global protection is on, `lock_mask` is 0x00, `map_mem` and `map_reg` hold their parameter defaults, and `rd_valid` and `eow` are low.
- R2: The unlock is three writes, using the in-plane offset addr[11:0] and either plane: 0xAA to 0x555, 0x55 to 0xAAA, then 0xA0 to 0x555. After it, one page write is accepted. A plain write made while protection is on and without an unlock is ignored.
- R3: A sequence step with the wrong address or data returns the sequencer to idle with nothing written. A step that comes more than LOAD_WIN clocks after the previous step also returns it to idle with nothing written.
- R4: A page is 1 to 32 bytes. The first byte fixes the page (addr[12:5]), and addr[4:0] selects the byte within it. Each next byte must come within LOAD_WIN clocks. Bytes aimed at a different page are dropped. Programming starts once the window lapses.
- R5: After the unlock, 0xAA to 0x555 and then a final byte to 0x555 opens a register. 0xC0 opens the lock mask, 0xD0 opens `map_mem` and 0xE0 opens `map_reg`. The next write, to any address, loads its data into the open register. Each such load turns global protection back on.
- R6: When `lock_mask` bit n is 1, writes into block n (addr[12:10] == n) are refused, even after a correct unlock.
- R7: Final byte 0x80 turns global protection off and leaves `lock_mask` unchanged. Plain writes are then accepted.
- R8: `rdata` is valid with `rd_valid` one clock after `rd_en`. During programming, reads of the busy plane return 0x40 and 0x00 alternately, starting with 0x40. Reads of the other plane return stored data.
- R9: If `wc_hi` is high while a page is loading, that page is discarded and no programming cycle runs.
- R10: A programming cycle lasts PROG_CYC clocks and ends with a one-cycle `eow` pulse. After it, the new data reads back.
- R11: Data writes that arrive while a programming cycle runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| wr_en | input | 1 | Decoded bus write event, one clock |
| rd_en | input | 1 | Decoded bus read event, one clock |
| addr | input | 13 | Array byte address; bit 12 picks the plane |
| wdata | input | 8 | Write data |
| wc_hi | input | 1 | Write-control inhibit; high discards a loading page |
| rdata | output | 8 | Read data or busy status byte |
| rd_valid | output | 1 | Marks `rdata` valid |
| eow | output | 1 | End-of-write pulse |
| lock_mask | output | 8 | Per-block write lock mask |
| map_mem | output | 8 | Memory map byte for the address decoder |
| map_reg | output | 8 | Register map byte for the address decoder |

## Verification
The bench builds the block with LOAD_WIN = 8 and PROG_CYC = 40 clocks, in place of the 100 µs and 5 ms real values. With these settings a lapsed command step, a full 32-byte page and several complete programming cycles all fit in a short run. The short busy period still leaves room for two status reads, a read of the other plane and a whole refused unlock-and-write attempt before `eow`. PLANE_AW stays at 12, so the fixed command offsets and the 1K block boundaries are the real ones.

// File: rtl/wg_pkg.sv
package wg_pkg;

   typedef enum logic [3:0] {
      ST_IDLE, ST_C1, ST_C2, ST_ARM, ST_C4,
      ST_LOCK, ST_MAPM, ST_MAPR, ST_PAGE
   } seq_st_t;

   localparam logic [7:0]  K_LEAD   = 8'hAA;
   localparam logic [7:0]  K_SECOND = 8'h55;
   localparam logic [7:0]  K_ARM    = 8'hA0;
   localparam logic [7:0]  K_LOCK   = 8'hC0;
   localparam logic [7:0]  K_MAPM   = 8'hD0;
   localparam logic [7:0]  K_MAPR   = 8'hE0;
   localparam logic [7:0]  K_OPEN   = 8'h80;
   localparam logic [11:0] OFS_LO   = 12'h555;
   localparam logic [11:0] OFS_HI   = 12'hAAA;

endpackage

// File: rtl/wg_cmd_seq.sv
module wg_cmd_seq
   import wg_pkg::*;
#(
   parameter int PLANE_AW   = 12,
   parameter int PG_AW      = 5,
   parameter int LOAD_WIN   = 5000,
   parameter logic [7:0] MAPM_INIT = 8'h07,
   parameter logic [7:0] MAPR_INIT = 8'h81
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [PLANE_AW:0]             addr,
   input  logic [7:0]                    wdata,
   input  logic                          wc_hi,
   input  logic                          eng_busy,
   output logic                          launch,
   output logic                          pg_plane,
   output logic [PLANE_AW-PG_AW-1:0]     pg_row,
   output logic [(1<<PG_AW)-1:0][7:0]    pg_data,
   output logic [(1<<PG_AW)-1:0]         pg_mask,
   output logic [7:0]                    lock_mask,
   output logic [7:0]                    map_mem,
   output logic [7:0]                    map_reg
);
   localparam int NPG   = 1 << PG_AW;
   localparam int ROW_W = PLANE_AW - PG_AW;
   localparam int TW    = $clog2(LOAD_WIN + 1);
   localparam logic [TW-1:0] T_LAST = TW'(LOAD_WIN - 1);

   seq_st_t st, nst;
   logic [TW-1:0] tmr;
   logic prot_on, discard;
   logic accept, try_pg, pg_start, pg_byte, expire, launch_d;
   logic ld_lock, ld_mapm, ld_mapr, prot_clr;

   logic                 hit_lo, hit_hi, plane_in, same_pg;
   logic [2:0]           blk;
   logic [PG_AW-1:0]     byte_ix;
   logic [ROW_W-1:0]     row_in;

   assign hit_lo   = addr[11:0] == OFS_LO;
   assign hit_hi   = addr[11:0] == OFS_HI;
   assign plane_in = addr[PLANE_AW];
   assign row_in   = addr[PLANE_AW-1:PG_AW];
   assign byte_ix  = addr[PG_AW-1:0];
   assign blk      = addr[PLANE_AW -: 3];
   assign same_pg  = (plane_in == pg_plane) && (row_in == pg_row);

   always_comb begin
      nst = st; accept = 1'b0; try_pg = 1'b0; pg_start = 1'b0; pg_byte = 1'b0;
      ld_lock = 1'b0; ld_mapm = 1'b0; ld_mapr = 1'b0; prot_clr = 1'b0; launch_d = 1'b0;
      if (wr_en) begin
         case (st)
            ST_IDLE: if (hit_lo && wdata == K_LEAD) begin nst = ST_C1; accept = 1'b1; end
                     else if (!prot_on) try_pg = 1'b1;
            ST_C1:   if (hit_hi && wdata == K_SECOND) begin nst = ST_C2; accept = 1'b1; end
                     else nst = ST_IDLE;
            ST_C2:   if (hit_lo && wdata == K_ARM) begin nst = ST_ARM; accept = 1'b1; end
                     else nst = ST_IDLE;
            ST_ARM:  if (hit_lo && wdata == K_LEAD) begin nst = ST_C4; accept = 1'b1; end
                     else try_pg = 1'b1;
            ST_C4: begin
               nst = ST_IDLE;
               if (hit_lo) begin
                  case (wdata)
                     K_LOCK:  begin nst = ST_LOCK; accept = 1'b1; end
                     K_MAPM:  begin nst = ST_MAPM; accept = 1'b1; end
                     K_MAPR:  begin nst = ST_MAPR; accept = 1'b1; end
                     K_OPEN:  prot_clr = 1'b1;
                     default: ;
                  endcase
               end
            end
            ST_LOCK: begin ld_lock = 1'b1; accept = 1'b1; nst = ST_IDLE; end
            ST_MAPM: begin ld_mapm = 1'b1; accept = 1'b1; nst = ST_IDLE; end
            ST_MAPR: begin ld_mapr = 1'b1; accept = 1'b1; nst = ST_IDLE; end
            ST_PAGE: if (same_pg) begin pg_byte = 1'b1; accept = 1'b1; end
            default: nst = ST_IDLE;
         endcase
      end
      if (try_pg) begin
         if (!eng_busy && !launch && !lock_mask[blk]) begin
            nst = ST_PAGE; pg_start = 1'b1; accept = 1'b1;
         end else begin
            nst = ST_IDLE;
         end
      end
      expire = (st != ST_IDLE) && !accept && (tmr >= T_LAST);
      if (expire) begin
         nst      = ST_IDLE;
         launch_d = (st == ST_PAGE) && !discard;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; tmr <= '0; launch <= 1'b0; prot_on <= 1'b1; discard <= 1'b0;
         lock_mask <= 8'h00; map_mem <= MAPM_INIT; map_reg <= MAPR_INIT;
         pg_mask <= '0; pg_plane <= 1'b0; pg_row <= '0;
      end else begin
         st     <= nst;
         launch <= launch_d;
         if (accept) tmr <= '0;
         else if (st != ST_IDLE && tmr < T_LAST) tmr <= tmr + 1'b1;
         if (ld_lock) lock_mask <= wdata;
         if (ld_mapm) map_mem <= wdata;
         if (ld_mapr) map_reg <= wdata;
         if (ld_lock || ld_mapm || ld_mapr) prot_on <= 1'b1;
         else if (prot_clr) prot_on <= 1'b0;
         if (pg_start) discard <= wc_hi;
         else if (st == ST_PAGE && wc_hi) discard <= 1'b1;
         if (pg_start) begin
            pg_mask  <= NPG'(1) << byte_ix;
            pg_plane <= plane_in;
            pg_row   <= row_in;
         end else if (pg_byte) begin
            pg_mask[byte_ix] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (pg_start || pg_byte) pg_data[byte_ix] <= wdata;
   end

   a_r5_mask_only_when_open: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lock_mask) |-> $past(st) == ST_LOCK);
   a_r5_guard_back_on: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && ($past(st) == ST_LOCK || $past(st) == ST_MAPM || $past(st) == ST_MAPR))
      |-> prot_on);
   a_r7_open_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_C4 && $past(wr_en) && $past(hit_lo) && $past(wdata) == K_OPEN)
      |-> ($stable(lock_mask) && !prot_on));

endmodule

// File: rtl/wg_prog_eng.sv
module wg_prog_eng #(
   parameter int PROG_CYC = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic launch_plane,
   output logic busy,
   output logic busy_plane,
   output logic eow
);
   localparam int CW = $clog2(PROG_CYC + 1);
   localparam logic [CW-1:0] C_LAST = CW'(PROG_CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; busy_plane <= 1'b0; eow <= 1'b0; cnt <= '0;
      end else begin
         eow <= 1'b0;
         if (launch) begin
            busy <= 1'b1; busy_plane <= launch_plane; cnt <= '0;
         end else if (busy) begin
            if (cnt == C_LAST) begin
               busy <= 1'b0; eow <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   a_r10_pulse_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> eow);
   a_r11_no_launch_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> !busy);

endmodule

// File: rtl/wg_plane.sv
module wg_plane #(
   parameter int PLANE_AW = 12,
   parameter int PG_AW    = 5,
   parameter int PLANE_ID = 0
) (
   input  logic                          clk,
   input  logic                          launch,
   input  logic                          pg_plane,
   input  logic [PLANE_AW-PG_AW-1:0]     pg_row,
   input  logic [(1<<PG_AW)-1:0][7:0]    pg_data,
   input  logic [(1<<PG_AW)-1:0]         pg_mask,
   input  logic                          rd_en,
   input  logic                          rd_plane,
   input  logic [PLANE_AW-1:0]           rd_addr,
   output logic [7:0]                    rd_q
);
   localparam int DEPTH = 1 << PLANE_AW;
   localparam int NPG   = 1 << PG_AW;
   localparam logic MY_ID = 1'(PLANE_ID);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (launch && pg_plane == MY_ID) begin
         for (int i = 0; i < NPG; i++) begin
            if (pg_mask[i]) mem[{pg_row, PG_AW'(i)}] <= pg_data[i];
         end
      end
      if (rd_en && rd_plane == MY_ID) rd_q <= mem[rd_addr];
   end

endmodule

// File: rtl/wg_write_guard.sv
module wg_write_guard #(
   parameter int PLANE_AW   = 12,
   parameter int PAGE_BYTES = 32,
   parameter int LOAD_WIN   = 5000,
   parameter int PROG_CYC   = 250000,
   parameter logic [7:0] MAPM_INIT = 8'h07,
   parameter logic [7:0] MAPR_INIT = 8'h81
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [PLANE_AW:0]    addr,
   input  logic [7:0]           wdata,
   input  logic                 wc_hi,
   output logic [7:0]           rdata,
   output logic                 rd_valid,
   output logic                 eow,
   output logic [7:0]           lock_mask,
   output logic [7:0]           map_mem,
   output logic [7:0]           map_reg
);
   localparam int PG_AW = $clog2(PAGE_BYTES);
   localparam int NPG   = 1 << PG_AW;
   localparam int ROW_W = PLANE_AW - PG_AW;

   if (PLANE_AW < 12) begin : g_bad_aw
      $error("PLANE_AW must reach the 12-bit command offsets");
   end
   if (NPG != PAGE_BYTES || PAGE_BYTES < 2) begin : g_bad_pg
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (LOAD_WIN < 2 || PROG_CYC < 2) begin : g_bad_tmr
      $error("LOAD_WIN and PROG_CYC must be at least 2");
   end

   logic                    launch, pg_plane, busy, busy_plane;
   logic [ROW_W-1:0]        pg_row;
   logic [NPG-1:0][7:0]     pg_data;
   logic [NPG-1:0]          pg_mask;
   logic [7:0]              plane_q [2];
   logic                    rd_plane_q, rd_busy_q, tog;
   logic [7:0]              stat_q;
   logic                    rd_hits_busy;

   wg_cmd_seq #(
      .PLANE_AW(PLANE_AW), .PG_AW(PG_AW), .LOAD_WIN(LOAD_WIN),
      .MAPM_INIT(MAPM_INIT), .MAPR_INIT(MAPR_INIT)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .wc_hi(wc_hi), .eng_busy(busy), .launch(launch), .pg_plane(pg_plane),
      .pg_row(pg_row), .pg_data(pg_data), .pg_mask(pg_mask),
      .lock_mask(lock_mask), .map_mem(map_mem), .map_reg(map_reg)
   );

   wg_prog_eng #(.PROG_CYC(PROG_CYC)) u_eng (
      .clk(clk), .rst_n(rst_n), .launch(launch), .launch_plane(pg_plane),
      .busy(busy), .busy_plane(busy_plane), .eow(eow)
   );

   for (genvar p = 0; p < 2; p++) begin : g_plane
      wg_plane #(.PLANE_AW(PLANE_AW), .PG_AW(PG_AW), .PLANE_ID(p)) u_plane (
         .clk(clk), .launch(launch), .pg_plane(pg_plane), .pg_row(pg_row),
         .pg_data(pg_data), .pg_mask(pg_mask), .rd_en(rd_en),
         .rd_plane(addr[PLANE_AW]), .rd_addr(addr[PLANE_AW-1:0]), .rd_q(plane_q[p])
      );
   end

   assign rd_hits_busy = busy && (busy_plane == addr[PLANE_AW]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0; rd_plane_q <= 1'b0; rd_busy_q <= 1'b0;
         tog <= 1'b0; stat_q <= 8'h00;
      end else begin
         rd_valid <= rd_en;
         if (launch) tog <= 1'b0;
         if (rd_en) begin
            rd_plane_q <= addr[PLANE_AW];
            rd_busy_q  <= rd_hits_busy;
            if (rd_hits_busy) begin
               stat_q <= {1'b0, ~tog, 6'b0};
               tog    <= ~tog;
            end
         end
      end
   end

   assign rdata = rd_busy_q ? stat_q : plane_q[rd_plane_q];

   a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   a_r11_launch_needs_idle_engine: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> !busy);

endmodule

// File: tb/test_wg_write_guard.sv
module test_wg_write_guard;
   localparam int LW = 8;
   localparam int PC = 40;
   localparam logic [7:0] MM0 = 8'h07;
   localparam logic [7:0] MR0 = 8'h81;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, wc_hi = 1'b0;
   logic [12:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata, lock_mask, map_mem, map_reg;
   logic        rd_valid, eow;

   wg_write_guard #(.PLANE_AW(12), .PAGE_BYTES(32), .LOAD_WIN(LW), .PROG_CYC(PC),
      .MAPM_INIT(MM0), .MAPR_INIT(MR0)) i_wg_write_guard (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .wc_hi(wc_hi), .rdata(rdata), .rd_valid(rd_valid), .eow(eow),
      .lock_mask(lock_mask), .map_mem(map_mem), .map_reg(map_reg));

   int checks = 0, failures = 0, eow_cnt = 0, exp_eow = 0;
   bit done = 1'b0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) if (rst_n && eow) eow_cnt++;

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) chk("R8 unexpected read", rdata, 8'hxx);
         else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
   end

   task automatic wr(input logic [12:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [12:0] a, input logic [7:0] e, input string tag);
      @(negedge clk); rd_en = 1'b1; addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic unlock();
      wr(13'h0555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h0555, 8'hA0);
   endtask

   task automatic ext(input logic [7:0] c);
      unlock(); wr(13'h0555, 8'hAA); wr(13'h0555, c);
   endtask

   task automatic settle();
      repeat (LW + PC + 6) @(negedge clk);
   endtask

   task automatic chk_eow(input string tag);
      checks++;
      if (eow_cnt != exp_eow) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, eow_cnt, exp_eow);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 lock_mask", lock_mask, 8'h00);
      chk("R1 map_mem", map_mem, MM0);
      chk("R1 map_reg", map_reg, MR0);
      chk("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
      chk("R1 eow", {7'b0, eow}, 8'h00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 / R4: unlocked page of four bytes
      unlock();
      wr(13'h0100, 8'h11); wr(13'h0101, 8'h22); wr(13'h0102, 8'h33); wr(13'h0103, 8'h44);
      settle(); exp_eow++;
      chk_eow("R10 eow after page");
      rd(13'h0100, 8'h11, "R2 unlocked byte 0");
      rd(13'h0103, 8'h44, "R4 page byte 3");
      unlock(); wr(13'h0410, 8'h21); settle(); exp_eow++;
      unlock(); wr(13'h1000, 8'h3C); wr(13'h1001, 8'hC3); settle(); exp_eow++;
      chk_eow("R10 eow count preload");

      // R2: plain write while protected
      wr(13'h0100, 8'h99); settle();
      rd(13'h0100, 8'h11, "R2 protected plain write ignored");

      // R3: wrong step, then late step
      wr(13'h0555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h0555, 8'hA1); wr(13'h0101, 8'h78);
      settle();
      rd(13'h0101, 8'h22, "R3 wrong data aborts");
      wr(13'h0555, 8'hAA); wr(13'h0AAA, 8'h55);
      repeat (LW + 4) @(negedge clk);
      wr(13'h0555, 8'hA0); wr(13'h0101, 8'h77); settle();
      rd(13'h0101, 8'h22, "R3 late step aborts");
      chk_eow("R3 no programming");

      // R9: write-control high discards page
      unlock(); wc_hi = 1'b1; wr(13'h0102, 8'h55); settle(); wc_hi = 1'b0;
      rd(13'h0102, 8'h33, "R9 discarded page");
      chk_eow("R9 no eow");

      // R8 / R11: busy plane status, other plane readable, writes ignored
      unlock(); wr(13'h0104, 8'h5A);
      repeat (LW + 3) @(negedge clk);
      rd(13'h0104, 8'h40, "R8 busy status first");
      rd(13'h0104, 8'h00, "R8 busy status second");
      rd(13'h1000, 8'h3C, "R8 other plane during busy");
      unlock(); wr(13'h1001, 8'h99);
      settle(); exp_eow++;
      chk_eow("R10 eow after busy cycle");
      rd(13'h0104, 8'h5A, "R10 data after programming");
      rd(13'h1001, 8'hC3, "R11 write during busy ignored");
      chk_eow("R11 no extra cycle");

      // R5 / R6: block lock
      ext(8'hC0); wr(13'h1FFF, 8'h02);
      @(negedge clk);
      chk("R5 lock mask loaded", lock_mask, 8'h02);
      wr(13'h0103, 8'hEE); settle();
      rd(13'h0103, 8'h44, "R5 protection back on after lock load");
      unlock(); wr(13'h0410, 8'hEE); settle();
      rd(13'h0410, 8'h21, "R6 locked block refused");
      unlock(); wr(13'h0010, 8'h10); settle(); exp_eow++;
      rd(13'h0010, 8'h10, "R6 unlocked block accepted");
      chk_eow("R6 eow count");

      // R5: map registers
      ext(8'hD0); wr(13'h0000, 8'h5B);
      @(negedge clk);
      chk("R5 map_mem loaded", map_mem, 8'h5B);
      ext(8'hE0); wr(13'h1234, 8'hC6);
      @(negedge clk);
      chk("R5 map_reg loaded", map_reg, 8'hC6);

      // R7: protection off keeps mask
      ext(8'h80);
      @(negedge clk);
      chk("R7 mask unchanged", lock_mask, 8'h02);
      wr(13'h0106, 8'h66); settle(); exp_eow++;
      rd(13'h0106, 8'h66, "R7 plain write accepted");

      // R4: full page with a stray byte
      wr(13'h0200, 8'h42); settle(); exp_eow++;
      for (int i = 0; i < 32; i++) begin
         if (i == 16) wr(13'h0200, 8'h99);
         wr(13'h0120 + 13'(i), 8'(i) ^ 8'hA5);
      end
      settle(); exp_eow++;
      chk_eow("R4 eow count");
      rd(13'h0120, 8'hA5, "R4 page first byte");
      rd(13'h0130, 8'hB5, "R4 page middle byte");
      rd(13'h013F, 8'hBA, "R4 page last byte");
      rd(13'h0200, 8'h42, "R4 stray byte dropped");
      repeat (4) @(negedge clk);
      chk("R8 scoreboard drained", 8'(exp_q.size()), 8'h00);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule